// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Turnaround Controller

This block drives a local bus whose address and data share the same lines. It runs each host request as a series of bus cycles: an address phase with the address-latch strobe high, then one data phase. It keeps track of whether the shared lines were released in the previous cycle. If they were, it puts exactly one idle turnaround cycle in front of the next address phase. If the block was still driving the lines, the address phase follows with no gap. When idle after a write, the block keeps driving the last write value, so back-to-back writes need no turnaround.

The host hands over one request at a time through a level `req_valid` with an operation code. A single acknowledge pulse marks the end of the request. The block supports plain reads, plain writes and read-modify-write. It also supports a read that carries a second address phase in mid-sequence. Read data comes back with a one-cycle valid pulse. A parameter adds released recovery cycles after every read data phase, to cover contention beyond a buffer on the bus.

Top module: `mbus_turn_ctrl`

## Requirements
- R1: After reset the block is idle (`bus_state`=0), `bus_oe`=0, `bus_ale`=0, `bus_rd`=0, `req_ack`=0 and `rd_valid`=0.
- R2: When the lines were released (`bus_oe`=0) in the cycle before an address phase would start, exactly one turnaround cycle comes first, with `bus_state`=1, `bus_oe`=0 and `bus_ale`=0.
- R3: When the lines were driven in the previous cycle, such as after a write or while idle and parked, the address phase follows at once with no turnaround cycle.
- R4: An address phase lasts one cycle, with `bus_state`=2, `bus_ale`=1, `bus_oe`=1 and `bus_out` equal to the address. The next cycle is always a data cycle, `bus_state`=3.
- R5: In a write data cycle `bus_oe`=1, `bus_rd`=0 and `bus_out` equals the write data.
- R6: In a read data cycle `bus_oe`=0 and `bus_rd`=1. `bus_in` is sampled at the end of that cycle and appears on `rd_data` during the following cycle, with `rd_valid` high for that one cycle.
- R7: Read-modify-write (`req_op`=2) is a read of `req_addr` followed by a write to the same address. The write value is taken from `req_wdata` at the end of the read's `rd_valid` cycle. The write address phase follows the R2 turnaround rule.
- R8: A read with an extra address phase (`req_op`=3) reads `req_addr`, then turns the bus around and reads `req_addr2`, giving one `rd_valid` pulse per read.
- R9: After every read data cycle, `GAP` released recovery cycles (`bus_state`=1, `bus_oe`=0) follow before any further idle or turnaround cycle.
- R10: `req_op` encodes 0=read, 1=write, 2=read-modify-write, 3=read with extra address. A request is taken only while idle with `req_ack` low. `req_ack` is high for exactly the one cycle that follows the last data cycle of the request.
- R11: While idle, `bus_oe` stays at the value of the last non-idle cycle. After a write the block keeps driving the last write data. After a read the lines stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code (R10) |
| req_addr | input | DW | First address |
| req_addr2 | input | DW | Extra-phase address for op 3 |
| req_wdata | input | DW | Write data, taken again for read-modify-write |
| req_ack | output | 1 | Request complete pulse |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Read data |
| bus_ale | output | 1 | Address-latch strobe |
| bus_oe | output | 1 | Drive enable for the shared lines |
| bus_out | output | DW | Value driven on the shared lines |
| bus_in | input | DW | Value seen on the shared lines |
| bus_rd | output | 1 | Read strobe |
| bus_state | output | 2 | 0 idle, 1 turnaround/recovery, 2 address, 3 data |

## Verification
The embedded assertions check several rules on every cycle. An address phase is always preceded either by a driven cycle or by a turnaround cycle. A turnaround never follows a driven cycle. Address is always followed by data, the strobe is only high while driving, and the acknowledge is a single pulse. The bench's scenarios are what show the values: the data actually read, and the modified word written back in read-modify-write. They also show the correct second address in the extra-phase read, the length of the recovery window and parking after writes. A behavioural reference model checks these cycle by cycle.

// File: rtl/mbt_pkg.sv
`timescale 1ns/1ps
package mbt_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_RMW = 2'd2,
    OP_RD2 = 2'd3
  } mbt_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TURN,
    S_ADDR,
    S_DATA,
    S_REC
  } mbt_st_e;

  // Externally visible phase code; recovery looks like turnaround on the pins.
  function automatic logic [1:0] st_code(mbt_st_e s);
    case (s)
      S_TURN, S_REC: return 2'd1;
      S_ADDR:        return 2'd2;
      S_DATA:        return 2'd3;
      default:       return 2'd0;
    endcase
  endfunction

  // Data phase drives the lines for plain writes and the write half of RMW.
  function automatic logic is_write_phase(mbt_op_e op, logic second);
    return (op == OP_WR) || (op == OP_RMW && second);
  endfunction

  // Ops that need another address phase after their first read.
  function automatic logic has_second_phase(mbt_op_e op, logic second);
    return !second && (op == OP_RMW || op == OP_RD2);
  endfunction
endpackage

// File: rtl/mbt_float_track.sv
`timescale 1ns/1ps
module mbt_float_track (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_now,
  output logic floating
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) floating <= 1'b1;
    else        floating <= !oe_now;
  end

  // R11
  drive_clears_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_now |=> !floating);
endmodule

// File: rtl/mbt_gap_timer.sv
`timescale 1ns/1ps
module mbt_gap_timer #(
  parameter int GAP = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_rec,
  output logic rec_last
);
  generate
    if (GAP == 0) begin : g_none
      logic unused_inputs;
      assign unused_inputs = start ^ in_rec ^ clk ^ rst_n;
      assign rec_last = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(GAP + 1);
      localparam logic [CW-1:0] LOADV = CW'(GAP);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt <= '0;
        else if (start)                   cnt <= LOADV;
        else if (in_rec && cnt != '0)     cnt <= cnt - 1'b1;
      end
      assign rec_last = (cnt == CW'(1));

      // R9
      gap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == LOADV));
    end
  endgenerate
endmodule

// File: rtl/mbt_seq.sv
`timescale 1ns/1ps
module mbt_seq
  import mbt_pkg::*;
#(
  parameter int GAP = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic       floating,
  input  logic       rec_last,
  output logic [1:0] code,
  output logic       oe,
  output logic       ale,
  output logic       rd,
  output logic       accept,
  output logic       rd_end,
  output logic       rec_start,
  output logic       in_rec,
  output logic       ack,
  output logic       use_addr2,
  output logic       rmw_op
);
  mbt_st_e cur, nxt;
  mbt_op_e op_q;
  logic    ph2, set_ph2, fin;
  logic    wr_phase, more;

  always_comb begin
    wr_phase  = is_write_phase(op_q, ph2);
    more      = has_second_phase(op_q, ph2);
    oe        = (cur == S_ADDR) || (cur == S_DATA && wr_phase) ||
                (cur == S_IDLE && !floating);
    ale       = (cur == S_ADDR);
    rd        = (cur == S_DATA) && !wr_phase;
    accept    = (cur == S_IDLE) && req_valid && !ack;
    rd_end    = rd;
    rec_start = rd && (GAP > 0);
    in_rec    = (cur == S_REC);
    fin       = (cur == S_DATA) && (wr_phase || !more);
    code      = st_code(cur);
    use_addr2 = ph2 && (op_q == OP_RD2);
    rmw_op    = (op_q == OP_RMW);
  end

  always_comb begin
    nxt     = cur;
    set_ph2 = 1'b0;
    case (cur)
      S_IDLE: if (accept) nxt = oe ? S_ADDR : S_TURN;
      S_TURN: nxt = S_ADDR;
      S_ADDR: nxt = S_DATA;
      S_DATA: begin
        if (wr_phase)      nxt = S_IDLE;
        else if (GAP > 0)  nxt = S_REC;
        else if (more) begin
          nxt     = S_TURN;
          set_ph2 = 1'b1;
        end else           nxt = S_IDLE;
      end
      S_REC: begin
        if (rec_last) begin
          if (more) begin
            nxt     = S_TURN;
            set_ph2 = 1'b1;
          end else nxt = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= S_IDLE;
      op_q <= OP_RD;
      ph2  <= 1'b0;
      ack  <= 1'b0;
    end else begin
      cur <= nxt;
      ack <= fin;
      if (accept) begin
        op_q <= mbt_op_e'(req_op);
        ph2  <= 1'b0;
      end else if (set_ph2) begin
        ph2 <= 1'b1;
      end
    end
  end

  // R2
  turn_before_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == S_ADDR) |-> ($past(oe) || $past(cur) == S_TURN));
  // R3
  no_spare_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == S_TURN) |-> !$past(oe));
  // R2
  turn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == S_TURN) |=> (cur == S_ADDR));
  // R4
  addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == S_ADDR) |=> (cur == S_DATA));
  // R4
  ale_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> oe);
  // R6
  rd_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> !oe);
  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R11
  idle_keeps_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == S_IDLE && $past(cur) == S_IDLE) |-> (oe == $past(oe)));
endmodule

// File: rtl/mbt_datapath.sv
`timescale 1ns/1ps
module mbt_datapath #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          rd_end,
  input  logic          rmw_op,
  input  logic          addr_phase,
  input  logic          use_addr2,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_addr2,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] addr_q, addr2_q, wdata_q;
  logic          rmw_take;

  assign rmw_take = rd_valid && rmw_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      addr2_q  <= '0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        addr2_q <= req_addr2;
        wdata_q <= req_wdata;
      end else if (rmw_take) begin
        wdata_q <= req_wdata;
      end
      rd_valid <= rd_end;
      if (rd_end) rd_data <= bus_in;
    end
  end

  assign bus_out = addr_phase ? (use_addr2 ? addr2_q : addr_q) : wdata_q;

  // R6
  rdv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R6
  rdv_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_end));
endmodule

// File: rtl/mbus_turn_ctrl.sv
`timescale 1ns/1ps
module mbus_turn_ctrl #(
  parameter int DW  = 16,
  parameter int GAP = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_addr2,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          bus_ale,
  output logic          bus_oe,
  output logic [DW-1:0] bus_out,
  input  logic [DW-1:0] bus_in,
  output logic          bus_rd,
  output logic [1:0]    bus_state
);
  logic floating, rec_last, accept, rd_end, rec_start, in_rec;
  logic use_addr2, rmw_op;

  mbt_float_track u_float (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_now   (bus_oe),
    .floating (floating)
  );

  mbt_gap_timer #(.GAP(GAP)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rec_start),
    .in_rec   (in_rec),
    .rec_last (rec_last)
  );

  mbt_seq #(.GAP(GAP)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .floating  (floating),
    .rec_last  (rec_last),
    .code      (bus_state),
    .oe        (bus_oe),
    .ale       (bus_ale),
    .rd        (bus_rd),
    .accept    (accept),
    .rd_end    (rd_end),
    .rec_start (rec_start),
    .in_rec    (in_rec),
    .ack       (req_ack),
    .use_addr2 (use_addr2),
    .rmw_op    (rmw_op)
  );

  mbt_datapath #(.DW(DW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .rd_end     (rd_end),
    .rmw_op     (rmw_op),
    .addr_phase (bus_ale),
    .use_addr2  (use_addr2),
    .req_addr   (req_addr),
    .req_addr2  (req_addr2),
    .req_wdata  (req_wdata),
    .bus_in     (bus_in),
    .bus_out    (bus_out),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  // R10
  ack_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> ($past(bus_state) == 2'd3));
endmodule

// File: tb/mbus_turn_ctrl_tb.sv
`timescale 1ns/1ps
module mbus_turn_ctrl_tb;
  localparam int DW  = 16;
  localparam int GAP = 1;
  localparam logic [DW-1:0] KEY = 16'h3C5A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [DW-1:0] req_addr = '0, req_addr2 = '0, req_wdata = '0;
  logic          req_ack, rd_valid, bus_ale, bus_oe, bus_rd;
  logic [DW-1:0] rd_data, bus_out, bus_in, dev_addr;
  logic [1:0]    bus_state;

  always #2.5 clk = ~clk;

  mbus_turn_ctrl #(.DW(DW), .GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_addr2(req_addr2), .req_wdata(req_wdata),
    .req_ack(req_ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .bus_ale(bus_ale), .bus_oe(bus_oe), .bus_out(bus_out), .bus_in(bus_in),
    .bus_rd(bus_rd), .bus_state(bus_state)
  );

  // Simple device: latches the address on the strobe, answers addr ^ KEY.
  always_ff @(posedge clk) if (bus_ale) dev_addr <= bus_out;
  assign bus_in = dev_addr ^ KEY;

  typedef struct {
    int            st;
    bit            ale, oe, rd, rdv, ack;
    logic [DW-1:0] out, rdd;
    string         tag;
  } rec_t;

  rec_t          q[$];
  int            checks = 0, failures = 0;
  bit            mf = 1'b1;
  bit            pend_rdv = 0, pend_ack = 0, last_ack = 0, rmw_mode = 0;
  logic [DW-1:0] pend_val = '0, mwd = '0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void push(int st, bit ale, bit oe, bit rd, logic [DW-1:0] out, string tag);
    rec_t r;
    r.st = st; r.ale = ale; r.oe = oe; r.rd = rd; r.out = out; r.tag = tag;
    r.rdv = pend_rdv; r.rdd = pend_val; r.ack = pend_ack;
    pend_rdv = 0; pend_ack = 0;
    mf = !oe;
    q.push_back(r);
  endfunction

  function automatic void gen_addr(logic [DW-1:0] a, string tag);
    if (mf) push(1, 0, 0, 0, '0, "R2");
    push(2, 1, 1, 0, a, mf ? tag : "R3");
  endfunction

  function automatic void gen_read(logic [DW-1:0] a, bit last, string tag);
    push(3, 0, 0, 1, '0, tag);
    pend_rdv = 1; pend_val = a ^ KEY;
    if (last) pend_ack = 1;
    for (int i = 0; i < GAP; i++) push(1, 0, 0, 0, '0, "R9");
  endfunction

  function automatic void gen_write(logic [DW-1:0] v, string tag);
    push(3, 0, 1, 0, v, tag);
    pend_ack = 1;
    mwd = v;
  endfunction

  task automatic tick();
    rec_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.st = 0; e.ale = 0; e.oe = !mf; e.rd = 0; e.rdv = 0; e.ack = 0;
      e.out = mwd; e.rdd = '0; e.tag = "R11";
    end
    chk(int'(bus_state) == e.st, e.tag, "R2 state", int'(bus_state), e.st);
    chk(bus_ale == e.ale, e.tag, "R4 ale", int'(bus_ale), int'(e.ale));
    chk(bus_oe == e.oe, e.tag, "R11 oe", int'(bus_oe), int'(e.oe));
    chk(bus_rd == e.rd, e.tag, "R6 rd", int'(bus_rd), int'(e.rd));
    if (e.oe) chk(bus_out == e.out, e.tag, "R5 out", int'(bus_out), int'(e.out));
    chk(req_ack == e.ack, e.tag, "R10 ack", int'(req_ack), int'(e.ack));
    chk(rd_valid == e.rdv, e.tag, "R6 rd_valid", int'(rd_valid), int'(e.rdv));
    if (e.rdv) chk(rd_data == e.rdd, e.tag, "R6 rd_data", int'(rd_data), int'(e.rdd));
    last_ack = e.ack;
    if (rmw_mode && rd_valid) req_wdata = ~rd_data;
  endtask

  // R10: op 0 read, 1 write, 2 rmw, 3 read with extra address phase
  task automatic do_op(int op, logic [DW-1:0] a, logic [DW-1:0] a2,
                       logic [DW-1:0] wd, string tag);
    while (q.size() != 0 || last_ack) tick();
    req_valid = 1; req_op = 2'(op); req_addr = a; req_addr2 = a2; req_wdata = wd;
    mwd = wd;
    rmw_mode = (op == 2);
    case (op)
      0: begin gen_addr(a, tag); gen_read(a, 1, tag); end
      1: begin gen_addr(a, tag); gen_write(wd, tag); end
      2: begin
        gen_addr(a, tag); gen_read(a, 0, tag);
        gen_addr(a, "R7"); gen_write(~(a ^ KEY), "R7");
      end
      default: begin
        gen_addr(a, tag); gen_read(a, 0, tag);
        gen_addr(a2, "R8"); gen_read(a2, 1, "R8");
      end
    endcase
    if (pend_rdv || pend_ack) push(0, 0, !mf, 0, mwd, "R10");
    tick();
    req_valid = 0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(bus_state == 2'd0, "R1", "state", int'(bus_state), 0);
    chk(bus_oe == 1'b0, "R1", "oe", int'(bus_oe), 0);
    chk(bus_ale == 1'b0, "R1", "ale", int'(bus_ale), 0);
    chk(req_ack == 1'b0, "R1", "ack", int'(req_ack), 0);
    chk(rd_valid == 1'b0, "R1", "rd_valid", int'(rd_valid), 0);
    repeat (3) tick();
    do_op(1, 16'h1234, 16'h0, 16'hA5A5, "R5");   // first access: turnaround
    do_op(1, 16'h0000, 16'h0, 16'h5A5A, "R3");   // write after write: none
    do_op(0, 16'hFFFF, 16'h0, 16'h0000, "R6");   // read after parked write
    do_op(0, 16'h0101, 16'h0, 16'h0000, "R2");   // read after read
    do_op(2, 16'h2468, 16'h0, 16'h0000, "R7");
    do_op(1, 16'h1357, 16'h0, 16'hC3C3, "R3");   // write after rmw write
    do_op(3, 16'h00F0, 16'h0F00, 16'h0000, "R8");
    do_op(2, 16'hFFFF, 16'h0, 16'h0000, "R7");
    do_op(3, 16'h0000, 16'hFFFF, 16'h0000, "R8");
    do_op(1, 16'h8001, 16'h0, 16'h7FFE, "R5");
    repeat (6) tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule